// File: doc/BRIEF.md
# DMA Controller Interrupt and Register File

This block is the software-visible state of a multi-channel DMA engine. It holds a controller configuration word, a sync word and five 32-bit words per channel: source address, destination address, link pointer, control and configuration. It also holds one raw terminal-count bit and one raw error bit per channel. The transfer engine lives elsewhere. It reaches this block only through per-channel one-cycle event pulses, and each pulse sets the matching raw bit.

Software reaches the state through a 4 KB window on a simple synchronous port. Each read returns its data one cycle after the request. The interrupt enables are not a separate register. Bit 15 of a channel's configuration word enables its terminal-count interrupt, and bit 14 enables its error interrupt. The block drives one interrupt line, which stays high while any enabled raw bit is set. Raw bits are cleared by writing ones to the two clear registers. The top of the window returns identification bytes, and one register reports which channels are enabled. The channel count is a parameter, normally 8 or 2.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `bus_rdata` is zero.
- R2: A read asserted at one clock edge places its data on `bus_rdata` after that edge. `bus_rdata` is zero after any edge where `bus_re` was low. Channel c's words sit at byte address 0x100 + 0x20*c + 4*w, with w = 0 source, 1 destination, 2 link pointer, 3 control and 4 configuration. All five are 32-bit read/write.
- R3: The controller configuration word at 0x030 and the sync word at 0x034 are 32-bit read/write.
- R4: A pulse on `evt_tc[c]` or `evt_err[c]` sets raw bit c, whatever the enables hold. The raw terminal-count bits read at 0x014 and the raw error bits read at 0x018, with bit c for channel c.
- R5: A write to 0x008 clears every raw terminal-count bit whose position is 1 in the write data. A write to 0x010 does the same for the raw error bits. An event arriving in the same cycle as a clear keeps its bit set.
- R6: Channel c's terminal-count enable is bit 15 of its configuration word, and its error enable is bit 14. The masked terminal-count status reads at 0x004 and the masked error status at 0x00C. Their OR reads at 0x000.
- R7: `irq_o` is high exactly while the masked terminal-count bits or the masked error bits are nonzero. It follows the register state after the same edge that updates that state.
- R8: The word at 0x01C returns bit 0 of each channel's configuration word, with channel c at bit c.
- R9: Reads from 0xFE0 through 0xFFC return one identification byte in bits 7:0, with the upper bits zero. In order the bytes are 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. A 2-channel build returns 0x81 as the first byte.
- R10: Undefined offsets read 0 and ignore writes. These are channel words 5 to 7, channel slots at or above the channel count, unlisted global words, and 0x200 to 0xFDF. The clear registers also read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_tc | input | NCH | Per-channel terminal-count event pulses |
| evt_err | input | NCH | Per-channel error event pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker watches four properties on every cycle:
- every event pulse lands in its raw bit, even when a clear arrives in the same cycle;
- a clear with no competing event empties the written bit positions;
- the interrupt stays low with no raw bits set and is low right after reset;
- undefined regions and idle cycles return zero data.

The bench scenarios cover the rest. They show that register contents survive writes to undefined offsets, and that the address decode and identification bytes are correct. They also show that a configuration write raises or masks the interrupt for bits that are already pending.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // configuration word bit positions
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_ERR_IE_BIT = 14;
    localparam int CFG_TC_IE_BIT  = 15;

    typedef enum logic [1:0] {
        RGN_GLOBAL,
        RGN_CHAN,
        RGN_ID,
        RGN_NONE
    } region_e;

    typedef enum logic [5:0] {
        GW_STAT     = 6'd0,
        GW_TC_STAT  = 6'd1,
        GW_TC_CLR   = 6'd2,
        GW_ERR_STAT = 6'd3,
        GW_ERR_CLR  = 6'd4,
        GW_TC_RAW   = 6'd5,
        GW_ERR_RAW  = 6'd6,
        GW_ENABLED  = 6'd7,
        GW_CTRL     = 6'd12,
        GW_SYNC     = 6'd13
    } gword_e;

    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTL  = 3'd3,
        CW_CFG  = 3'd4
    } cword_e;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] link;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] cfg;
    } chan_regs_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a[11:8] == 4'h0)       return RGN_GLOBAL;
        else if (a[11:8] == 4'h1)  return RGN_CHAN;
        else if (a >= 12'hFE0)     return RGN_ID;
        else                       return RGN_NONE;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        case (idx)
            3'd0:    return (nch == 2) ? 8'h81 : 8'h80;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cword_e            word,
    input  logic [DATA_W-1:0] wdata,
    output chan_regs_t        regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (word)
                CW_SRC:  regs.src  <= wdata;
                CW_DST:  regs.dst  <= wdata;
                CW_LINK: regs.link <= wdata;
                CW_CTL:  regs.ctl  <= wdata;
                CW_CFG:  regs.cfg  <= wdata;
                default: ; // words 5..7: no storage
            endcase
        end
    end

endmodule

// File: rtl/dma_rf_irq.sv
module dma_rf_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt_tc,
    input  logic [NCH-1:0] evt_err,
    input  logic           tc_clr_we,
    input  logic           err_clr_we,
    input  logic [NCH-1:0] clr_data,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] raw_tc,
    output logic [NCH-1:0] raw_err,
    output logic [NCH-1:0] tc_masked,
    output logic [NCH-1:0] err_masked,
    output logic           irq
);

    logic [NCH-1:0] tc_kill, err_kill;

    always_comb begin
        tc_kill  = tc_clr_we  ? clr_data : '0;
        err_kill = err_clr_we ? clr_data : '0;
    end

    // a set from an event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_tc  <= '0;
            raw_err <= '0;
        end else begin
            raw_tc  <= (raw_tc  & ~tc_kill)  | evt_tc;
            raw_err <= (raw_err & ~err_kill) | evt_err;
        end
    end

    always_comb begin
        tc_masked  = raw_tc  & tc_mask;
        err_masked = raw_err & err_mask;
        irq        = |(tc_masked | err_masked);
    end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    evt_tc,
    input  logic [NCH-1:0]    evt_err,
    output logic              irq_o
);

    localparam int SLOT_W = 3;

    region_e           rgn;
    gword_e            gword;
    cword_e            cword;
    logic [SLOT_W-1:0] slot;
    logic              glob_we;

    always_comb begin
        rgn     = region_of(bus_addr);
        gword   = gword_e'(bus_addr[7:2]);
        cword   = cword_e'(bus_addr[4:2]);
        slot    = bus_addr[7:5];
        glob_we = bus_we && (rgn == RGN_GLOBAL);
    end

    // global words
    logic [DATA_W-1:0] ctrl_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sync_q <= '0;
        end else if (glob_we) begin
            if (gword == GW_CTRL) ctrl_q <= bus_wdata;
            if (gword == GW_SYNC) sync_q <= bus_wdata;
        end
    end

    // channels
    chan_regs_t     ch_q [NCH];
    logic [NCH-1:0] tc_mask, err_mask, ch_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_we;
        assign sel_we = bus_we && (rgn == RGN_CHAN) && (slot == SLOT_W'(c));

        dma_rf_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (sel_we),
            .word  (cword),
            .wdata (bus_wdata),
            .regs  (ch_q[c])
        );

        assign tc_mask[c]  = ch_q[c].cfg[CFG_TC_IE_BIT];
        assign err_mask[c] = ch_q[c].cfg[CFG_ERR_IE_BIT];
        assign ch_en[c]    = ch_q[c].cfg[CFG_EN_BIT];
    end

    // interrupt state
    logic [NCH-1:0] raw_tc, raw_err, tc_masked, err_masked;

    dma_rf_irq #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .evt_tc     (evt_tc),
        .evt_err    (evt_err),
        .tc_clr_we  (glob_we && (gword == GW_TC_CLR)),
        .err_clr_we (glob_we && (gword == GW_ERR_CLR)),
        .clr_data   (bus_wdata[NCH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .raw_tc     (raw_tc),
        .raw_err    (raw_err),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq        (irq_o)
    );

    // read path
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (rgn)
            RGN_GLOBAL: begin
                case (gword)
                    GW_STAT:     rd_val[NCH-1:0] = tc_masked | err_masked;
                    GW_TC_STAT:  rd_val[NCH-1:0] = tc_masked;
                    GW_ERR_STAT: rd_val[NCH-1:0] = err_masked;
                    GW_TC_RAW:   rd_val[NCH-1:0] = raw_tc;
                    GW_ERR_RAW:  rd_val[NCH-1:0] = raw_err;
                    GW_ENABLED:  rd_val[NCH-1:0] = ch_en;
                    GW_CTRL:     rd_val = ctrl_q;
                    GW_SYNC:     rd_val = sync_q;
                    default:     rd_val = '0;
                endcase
            end
            RGN_CHAN: begin
                for (int c = 0; c < NCH; c++) begin
                    if (slot == SLOT_W'(c)) begin
                        case (cword)
                            CW_SRC:  rd_val = ch_q[c].src;
                            CW_DST:  rd_val = ch_q[c].dst;
                            CW_LINK: rd_val = ch_q[c].link;
                            CW_CTL:  rd_val = ch_q[c].ctl;
                            CW_CFG:  rd_val = ch_q[c].cfg;
                            default: rd_val = '0;
                        endcase
                    end
                end
            end
            RGN_ID:  rd_val[7:0] = id_byte(bus_addr[4:2], NCH);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
    import dma_rf_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NCH-1:0]    evt_tc,
    input logic [NCH-1:0]    evt_err,
    input logic              irq_o,
    input logic [NCH-1:0]    raw_tc,
    input logic [NCH-1:0]    raw_err
);

    a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);

    a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == '0);

    a_r4_tc_event_sets: assert property (@(posedge clk) disable iff (rst)
        evt_tc != '0 |=> (raw_tc & $past(evt_tc)) == $past(evt_tc));

    a_r4_err_event_sets: assert property (@(posedge clk) disable iff (rst)
        evt_err != '0 |=> (raw_err & $past(evt_err)) == $past(evt_err));

    a_r5_tc_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 12'h008 && evt_tc == '0)
        |=> (raw_tc & $past(bus_wdata[NCH-1:0])) == '0);

    a_r5_err_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 12'h010 && evt_err == '0)
        |=> (raw_err & $past(bus_wdata[NCH-1:0])) == '0);

    a_r7_no_raw_no_irq: assert property (@(posedge clk) disable iff (rst)
        (raw_tc == '0 && raw_err == '0) |-> !irq_o);

    a_r10_undefined_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && region_of(bus_addr) == RGN_NONE) |=> bus_rdata == '0);

endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_tc    (evt_tc),
    .evt_err   (evt_err),
    .irq_o     (irq_o),
    .raw_tc    (raw_tc),
    .raw_err   (raw_err)
);

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] evt_tc = '0;
    logic [NCH-1:0] evt_err = '0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dma_regfile #(.NCH(NCH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_tc    (evt_tc),
        .evt_err   (evt_err),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    // rd=0: write data; rd=1: read and compare with data
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd2,  12'h100, 32'h11111111},  // R2 channel 0 words
        '{1'b0, 4'd2,  12'h104, 32'h22222222},
        '{1'b0, 4'd2,  12'h108, 32'h33333330},
        '{1'b0, 4'd2,  12'h10C, 32'h44444444},
        '{1'b0, 4'd2,  12'h110, 32'h0000C001},
        '{1'b0, 4'd8,  12'h1F0, 32'h00000001},  // R8 channel 7 enabled
        '{1'b1, 4'd2,  12'h100, 32'h11111111},
        '{1'b1, 4'd2,  12'h104, 32'h22222222},
        '{1'b1, 4'd2,  12'h108, 32'h33333330},
        '{1'b1, 4'd2,  12'h10C, 32'h44444444},
        '{1'b1, 4'd2,  12'h110, 32'h0000C001},
        '{1'b1, 4'd2,  12'h1F0, 32'h00000001},
        '{1'b1, 4'd8,  12'h01C, 32'h00000081},  // R8
        '{1'b0, 4'd3,  12'h030, 32'hA5A5A5A5},  // R3
        '{1'b0, 4'd3,  12'h034, 32'h0000FFFF},
        '{1'b1, 4'd3,  12'h030, 32'hA5A5A5A5},
        '{1'b1, 4'd3,  12'h034, 32'h0000FFFF},
        '{1'b1, 4'd9,  12'hFE0, 32'h00000080},  // R9
        '{1'b1, 4'd9,  12'hFE4, 32'h00000010},
        '{1'b1, 4'd9,  12'hFFC, 32'h000000B1},
        '{1'b0, 4'd10, 12'h114, 32'hDEADBEEF},  // R10 channel word 5
        '{1'b1, 4'd10, 12'h114, 32'h00000000},
        '{1'b0, 4'd10, 12'h040, 32'h12345678},  // R10 unlisted global
        '{1'b1, 4'd10, 12'h040, 32'h00000000},
        '{1'b1, 4'd10, 12'h008, 32'h00000000},  // R10 clear reads 0
        '{1'b0, 4'd10, 12'h800, 32'hCAFEF00D},
        '{1'b1, 4'd10, 12'h800, 32'h00000000},
        '{1'b1, 4'd10, 12'h110, 32'h0000C001},  // R10 nothing disturbed
        '{1'b1, 4'd10, 12'h030, 32'hA5A5A5A5},
        '{1'b1, 4'd10, 12'h100, 32'h11111111}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [NCH-1:0] tc, input logic [NCH-1:0] er);
        @(negedge clk);
        evt_tc = tc; evt_err = er;
        @(negedge clk);
        evt_tc = '0; evt_err = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(12'h014, 32'h0, "R1 raw tc");
        rd(12'h110, 32'h0, "R1 ch0 cfg");
        rd(12'h030, 32'h0, "R1 ctrl");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) rd(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i));
            else           wr(VEC[i].addr, VEC[i].data);
        end

        // R4 R6 R7: ch0 enables both, ch7 enables neither
        pulse(8'h81, 8'h00);
        check("R7 irq after tc", {31'b0, irq_o}, 32'h1);
        rd(12'h014, 32'h81, "R4 raw tc");
        rd(12'h004, 32'h01, "R6 masked tc");
        rd(12'h000, 32'h01, "R6 combined");

        // R5 clear ch0
        wr(12'h008, 32'h00000001);
        check("R5 irq after clear", {31'b0, irq_o}, 32'h0);
        rd(12'h014, 32'h80, "R5 raw tc kept ch7");

        // R4 error on masked channel
        pulse(8'h00, 8'h80);
        check("R7 irq masked err", {31'b0, irq_o}, 32'h0);
        rd(12'h018, 32'h80, "R4 raw err");
        rd(12'h00C, 32'h00, "R6 masked err off");

        // R6 enabling the error interrupt exposes pending bit
        wr(12'h1F0, 32'h00004001);
        check("R6 irq on enable", {31'b0, irq_o}, 32'h1);
        rd(12'h00C, 32'h80, "R6 masked err on");
        rd(12'h000, 32'h80, "R6 combined err");

        // R5 event wins over simultaneous clear
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h80; evt_err = 8'h80;
        @(negedge clk);
        bus_we = 1'b0; evt_err = '0;
        rd(12'h018, 32'h80, "R5 event beats clear");
        wr(12'h010, 32'h000000FF);
        rd(12'h018, 32'h00, "R5 err cleared");
        check("R7 irq low at end", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule